// File: doc/BRIEF.md
# Temperature-Indexed Dual Look-Up DAC Code Controller

This block turns one shared temperature sample from an 8-bit ADC into two 8-bit DAC codes. Each output channel owns a 64-entry table of DAC codes. A conversion strobe indexes each table with the upper six bits of the sample, and the selected entry becomes that channel's DAC code on the next clock edge. Each channel also has two independent overrides. One replaces the sample-derived index with a fixed 6-bit table address. The other bypasses the table and drives a fixed 8-bit code.

After reset both DAC codes stay at zero until the incoming conversions are trusted. With the filter enabled, a conversion is trusted only when its code equals the code of the conversion just before it. With the filter disabled, the first conversion is trusted. Once trusted, every later conversion updates the outputs until the next reset.

A write port loads either table at any time. Each channel also carries a source/sink direction bit through to its current generator.

Top module: `tclut_dac_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `dac_code` is all zeros and `dac_sink` is all zeros (source).
- R2: Until the first qualifying conversion, both DAC codes stay 00h, whatever the overrides, the table contents or the unqualified strobes.
- R3: With `filter_off` = 1, the first strobe after reset qualifies, and its result appears on `dac_code` one clock after the strobe.
- R4: With `filter_off` = 0, a strobe qualifies only if its `adc_code` equals the `adc_code` of the previous strobe since reset. Earlier strobes leave the outputs at 00h. After qualification every strobe updates the outputs until reset.
- R5: When channel c has `tab_dir_sel[c]` = 0, its table index is `adc_code[7:2]`.
- R6: When `tab_dir_sel[c]` = 1, channel c's table index is `tab_dir_addr[6c+5:6c]`, and `adc_code` is ignored for that channel.
- R7: When `dac_dir_sel[c]` = 1, a qualified strobe loads `dac_code[8c+7:8c]` with `dac_dir_code[8c+7:8c]` instead of the table entry.
- R8: `dac_code` changes only on a clock edge at which `adc_valid` is sampled high. Channel 0 uses the low byte and channel 1 the high byte.
- R9: A write with `wr_en` = 1 stores `wr_data` at `wr_addr` in the table chosen by `wr_chan` (0 selects channel 0, 1 selects channel 1). It leaves the other table untouched.
- R10: If a write and a strobe read the same entry on the same edge, the strobe gets the entry's old content. The new content is seen by the next strobe.
- R11: `dac_sink[c]` equals `sink_sel[c]` as sampled on the previous clock edge, where 0 means source and 1 means sink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_code | input | 8 | Temperature conversion result |
| adc_valid | input | 1 | One-cycle strobe marking a new conversion |
| filter_off | input | 1 | 1: first conversion qualifies; 0: two equal consecutive conversions needed |
| tab_dir_sel | input | 2 | Per channel, index the table from `tab_dir_addr` |
| tab_dir_addr | input | 12 | Per-channel 6-bit fixed table index |
| dac_dir_sel | input | 2 | Per channel, drive the DAC from `dac_dir_code` |
| dac_dir_code | input | 16 | Per-channel 8-bit fixed DAC code |
| sink_sel | input | 2 | Per-channel direction request, 1 = sink |
| wr_en | input | 1 | Table write enable |
| wr_chan | input | 1 | Table chosen by a write |
| wr_addr | input | 6 | Table entry written |
| wr_data | input | 8 | Data written |
| dac_code | output | 16 | DAC codes, channel 0 in the low byte |
| dac_sink | output | 2 | Per-channel direction, 1 = sink |

## Verification
A table write and a conversion strobe can hit the same entry on the same clock edge. The bench provokes this by driving the write and the strobe in one cycle at one address. It expects the old entry on the output, then the new entry after a second strobe. Qualification and the first update also share an edge: the agreeing strobe must both arm the block and load the outputs. The bench checks the outputs are still zero after the disagreeing strobes and hold the table value right after the agreeing one.

// File: rtl/tclut_pkg.sv
package tclut_pkg;
   localparam int unsigned TCL_ADC_W = 8;
   localparam int unsigned TCL_IDX_W = 6;
   localparam int unsigned TCL_DAC_W = 8;
   localparam int unsigned TCL_NCH   = 2;

   typedef enum logic {TCL_SOURCE = 1'b0, TCL_SINK = 1'b1} tcl_dir_e;
endpackage

// File: rtl/tclut_qual.sv
module tclut_qual #(
   parameter int unsigned ADC_W      = tclut_pkg::TCL_ADC_W,
   parameter bit          HAS_FILTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADC_W-1:0] adc_code,
   input  logic             adc_valid,
   input  logic             filter_off,
   output logic             upd
);
   logic             ready_q;
   logic             qualify;

   generate
      if (HAS_FILTER) begin : g_filt
         logic             have_q;
         logic [ADC_W-1:0] prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               have_q <= 1'b0;
               prev_q <= '0;
            end else if (adc_valid) begin
               have_q <= 1'b1;
               prev_q <= adc_code;
            end
         end
         assign qualify = filter_off || (have_q && (prev_q == adc_code));
      end else begin : g_nofilt
         assign qualify = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ready_q <= 1'b0;
      else if (adc_valid && qualify) ready_q <= 1'b1;
   end

   assign upd = adc_valid && (ready_q || qualify);
endmodule

// File: rtl/tclut_table.sv
module tclut_table #(
   parameter int unsigned IDX_W = tclut_pkg::TCL_IDX_W,
   parameter int unsigned DAT_W = tclut_pkg::TCL_DAC_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [DAT_W-1:0] wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [DAT_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DAT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tclut_chan.sv
module tclut_chan #(
   parameter int unsigned ADC_W = tclut_pkg::TCL_ADC_W,
   parameter int unsigned IDX_W = tclut_pkg::TCL_IDX_W,
   parameter int unsigned DAC_W = tclut_pkg::TCL_DAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADC_W-1:0] adc_code,
   input  logic             upd,
   input  logic             tab_sel,
   input  logic [IDX_W-1:0] tab_addr,
   input  logic             dac_sel,
   input  logic [DAC_W-1:0] dac_fix,
   input  logic             sink_req,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [DAC_W-1:0] wdata,
   output logic [DAC_W-1:0] code_q,
   output logic             sink_q
);
   localparam int unsigned SHIFT = ADC_W - IDX_W;

   logic [IDX_W-1:0] idx;
   logic [DAC_W-1:0] entry;

   assign idx = tab_sel ? tab_addr : adc_code[ADC_W-1 -: IDX_W];

   tclut_table #(.IDX_W(IDX_W), .DAT_W(DAC_W)) u_tab (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (idx),
      .rdata (entry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         sink_q <= tclut_pkg::TCL_SOURCE;
      end else begin
         sink_q <= sink_req;
         if (upd) code_q <= dac_sel ? dac_fix : entry;
      end
   end

   generate
      if (SHIFT > ADC_W) begin : g_bad_shift
         $error("tclut_chan: index wider than sample");
      end
   endgenerate
endmodule

// File: rtl/tclut_dac_ctrl.sv
module tclut_dac_ctrl #(
   parameter int unsigned NCH        = tclut_pkg::TCL_NCH,
   parameter int unsigned ADC_W      = tclut_pkg::TCL_ADC_W,
   parameter int unsigned IDX_W      = tclut_pkg::TCL_IDX_W,
   parameter int unsigned DAC_W      = tclut_pkg::TCL_DAC_W,
   parameter bit          HAS_FILTER = 1'b1,
   localparam int unsigned CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADC_W-1:0]       adc_code,
   input  logic                   adc_valid,
   input  logic                   filter_off,
   input  logic [NCH-1:0]         tab_dir_sel,
   input  logic [NCH*IDX_W-1:0]   tab_dir_addr,
   input  logic [NCH-1:0]         dac_dir_sel,
   input  logic [NCH*DAC_W-1:0]   dac_dir_code,
   input  logic [NCH-1:0]         sink_sel,
   input  logic                   wr_en,
   input  logic [CH_W-1:0]        wr_chan,
   input  logic [IDX_W-1:0]       wr_addr,
   input  logic [DAC_W-1:0]       wr_data,
   output logic [NCH*DAC_W-1:0]   dac_code,
   output logic [NCH-1:0]         dac_sink
);
   generate
      if (IDX_W > ADC_W) begin : g_bad_idx
         $error("tclut_dac_ctrl: IDX_W must not exceed ADC_W");
      end
      if (NCH < 1) begin : g_bad_nch
         $error("tclut_dac_ctrl: NCH must be at least 1");
      end
   endgenerate

   logic upd;

   tclut_qual #(.ADC_W(ADC_W), .HAS_FILTER(HAS_FILTER)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .adc_code   (adc_code),
      .adc_valid  (adc_valid),
      .filter_off (filter_off),
      .upd        (upd)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic we_c;
      assign we_c = wr_en && (wr_chan == CH_W'(c));

      tclut_chan #(.ADC_W(ADC_W), .IDX_W(IDX_W), .DAC_W(DAC_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .adc_code (adc_code),
         .upd      (upd),
         .tab_sel  (tab_dir_sel[c]),
         .tab_addr (tab_dir_addr[c*IDX_W +: IDX_W]),
         .dac_sel  (dac_dir_sel[c]),
         .dac_fix  (dac_dir_code[c*DAC_W +: DAC_W]),
         .sink_req (sink_sel[c]),
         .we       (we_c),
         .waddr    (wr_addr),
         .wdata    (wr_data),
         .code_q   (dac_code[c*DAC_W +: DAC_W]),
         .sink_q   (dac_sink[c])
      );
   end
endmodule

// File: rtl/tclut_dac_ctrl_chk.sv
module tclut_dac_ctrl_chk #(
   parameter int unsigned NCH   = 2,
   parameter int unsigned ADC_W = 8,
   parameter int unsigned DAC_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 adc_valid,
   input logic                 filter_off,
   input logic [NCH-1:0]       dac_dir_sel,
   input logic [NCH*DAC_W-1:0] dac_dir_code,
   input logic [NCH-1:0]       sink_sel,
   input logic [NCH*DAC_W-1:0] dac_code,
   input logic [NCH-1:0]       dac_sink
);
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_q <= 1'b0;
      else if (adc_valid) seen_q <= 1'b1;
   end

   a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> dac_code == '0);

   a_r4_first_filtered: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_valid && !filter_off && !seen_q) |=> dac_code == '0);

   a_r8_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_valid |=> $stable(dac_code));

   a_r11_sink_follow: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> dac_sink == $past(sink_sel));

   for (genvar c = 0; c < NCH; c++) begin : g_chk
      a_r7_direct_code: assert property (@(posedge clk) disable iff (!rst_n)
         (adc_valid && filter_off && dac_dir_sel[c])
         |=> dac_code[c*DAC_W +: DAC_W] == $past(dac_dir_code[c*DAC_W +: DAC_W]));
   end
endmodule

bind tclut_dac_ctrl tclut_dac_ctrl_chk #(.NCH(NCH), .ADC_W(ADC_W), .DAC_W(DAC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .adc_valid    (adc_valid),
   .filter_off   (filter_off),
   .dac_dir_sel  (dac_dir_sel),
   .dac_dir_code (dac_dir_code),
   .sink_sel     (sink_sel),
   .dac_code     (dac_code),
   .dac_sink     (dac_sink)
);

// File: tb/sim_tclut_dac_ctrl.sv
module sim_tclut_dac_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  adc_code = '0;
   logic        adc_valid = 1'b0;
   logic        filter_off = 1'b0;
   logic [1:0]  tab_dir_sel = '0;
   logic [11:0] tab_dir_addr = '0;
   logic [1:0]  dac_dir_sel = '0;
   logic [15:0] dac_dir_code = '0;
   logic [1:0]  sink_sel = '0;
   logic        wr_en = 1'b0;
   logic [0:0]  wr_chan = '0;
   logic [5:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] dac_code;
   logic [1:0]  dac_sink;

   int checks = 0;
   int errors = 0;
   logic [7:0] m0 [64];
   logic [7:0] m1 [64];

   always #(CLK_P/2) clk = ~clk;

   tclut_dac_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .adc_code(adc_code), .adc_valid(adc_valid),
      .filter_off(filter_off), .tab_dir_sel(tab_dir_sel), .tab_dir_addr(tab_dir_addr),
      .dac_dir_sel(dac_dir_sel), .dac_dir_code(dac_dir_code), .sink_sel(sink_sel),
      .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_data(wr_data),
      .dac_code(dac_code), .dac_sink(dac_sink)
   );

   task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic ch, input logic [5:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_chan = ch; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (ch) m1[a] = d; else m0[a] = d;
   endtask

   task automatic strobe(input logic [7:0] code);
      adc_code = code; adc_valid = 1'b1;
      @(negedge clk);
      adc_valid = 1'b0;
   endtask

   function automatic logic [15:0] tabx(input int i0, input int i1);
      return {m1[i1], m0[i0]};
   endfunction

   task automatic t_reset();
      chk16("R1 code", dac_code, 16'h0000);
      chk16("R1 sink", {14'd0, dac_sink}, 16'h0000);
      for (int i = 0; i < 64; i++) begin
         wr(1'b0, 6'(i), 8'(i * 3 + 1));
         wr(1'b1, 6'(i), 8'(255 - i));
      end
      chk16("R2 after writes", dac_code, 16'h0000);
   endtask

   task automatic t_filter_on();
      filter_off = 1'b0;
      strobe(8'h40);
      chk16("R4 first strobe", dac_code, 16'h0000);
      strobe(8'h80);
      chk16("R4 disagree", dac_code, 16'h0000);
      strobe(8'h80);
      chk16("R4 R5 agree", dac_code, tabx(32, 32));
      strobe(8'h13);
      chk16("R4 sticky", dac_code, tabx(4, 4));
   endtask

   task automatic t_no_strobe();
      logic [15:0] held;
      held = dac_code;
      adc_code = 8'hFC;
      repeat (3) @(negedge clk);
      chk16("R8 stable", dac_code, held);
   endtask

   task automatic t_tab_direct();
      tab_dir_sel = 2'b01; tab_dir_addr = {6'd0, 6'd63};
      strobe(8'h00);
      chk16("R6 ch0 direct", dac_code, tabx(63, 0));
      tab_dir_sel = 2'b11; tab_dir_addr = {6'd10, 6'd2};
      strobe(8'hF0);
      chk16("R6 both direct", dac_code, tabx(2, 10));
      tab_dir_sel = 2'b00;
   endtask

   task automatic t_dac_direct();
      dac_dir_sel = 2'b10; dac_dir_code = 16'hA55A;
      strobe(8'h28);
      chk16("R7 ch1 fixed", dac_code, {8'hA5, m0[10]});
      dac_dir_sel = 2'b00;
   endtask

   task automatic t_write_iso();
      wr(1'b1, 6'd5, 8'h5A);
      strobe(8'h14);
      chk16("R9 isolation", dac_code, {8'h5A, m0[5]});
   endtask

   task automatic t_collide();
      logic [15:0] old;
      old = tabx(7, 7);
      wr_en = 1'b1; wr_chan = 1'b0; wr_addr = 6'd7; wr_data = 8'hC3;
      adc_code = 8'h1C; adc_valid = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; adc_valid = 1'b0;
      m0[7] = 8'hC3;
      chk16("R10 old data", dac_code, old);
      strobe(8'h1C);
      chk16("R10 new data", dac_code, tabx(7, 7));
   endtask

   task automatic t_sink();
      sink_sel = 2'b10;
      @(negedge clk);
      chk16("R11 sink", {14'd0, dac_sink}, 16'h0002);
      sink_sel = 2'b01;
      @(negedge clk);
      chk16("R11 swap", {14'd0, dac_sink}, 16'h0001);
   endtask

   task automatic t_filter_off();
      filter_off = 1'b1;
      do_reset();
      chk16("R1 R2 re-reset", dac_code, 16'h0000);
      strobe(8'h24);
      chk16("R3 first qualifies", dac_code, tabx(9, 9));
   endtask

   initial begin
      fork
         begin
            do_reset();
            t_reset();
            t_filter_on();
            t_no_strobe();
            t_tab_direct();
            t_dac_direct();
            t_write_iso();
            t_collide();
            t_sink();
            t_filter_off();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule